// File: doc/BRIEF.md
# Pixel-Aligned ADC Clock Divider

This block derives the conversion clock for a video sampling ADC from the 100 MHz system clock. It produces two forms of that clock. One is a square wave on `adc_clk`, taken straight from a state-register bit. The other is a one-cycle strobe, `sample_stb`, on the system clock at each rising edge of `adc_clk`, which downstream capture logic uses to pick up samples. A small code on `rate_sel` selects the division ratio: 4, 8 or 16, which gives 25, 12.5 or 6.25 MHz.

The pixel sequencer does not run with fixed loop timing. A free-running divider would therefore put the first conversion of each pixel at a different point, and that offset shows up as level steps in bias frames. To avoid this, every rising edge on `pix_sync` realigns the divider. The divider never cuts short the phase that is in progress. A high phase runs to its full length. The clock is then held low, which stretches the low phase, until a fixed alignment delay has passed since the sync edge. A fresh period then starts with a rising edge. The ratio code is captured only at that sync edge and applied when the new period starts, so no runt pulse can occur.

The controller has five named states:
- `ST_IDLE`: clock stopped low after reset.
- `ST_RUN_HI` and `ST_RUN_LO`: the two free-running halves.
- `ST_HOLD_HI`: a high half being completed after a sync.
- `ST_HOLD_LO`: the stretched low phase that waits for alignment.

The transitions are:
- Idle to hold-low on the first sync.
- Run-high to run-low, and run-low to run-high, at the end of a half.
- Run-high to hold-high on a sync that lands mid-high, or to hold-low if the high half ends on that edge.
- Run-low to hold-low on a sync.
- Hold-high to hold-low when its half completes.
- Hold-low to run-high when the alignment count expires.

A sync seen in either hold state restarts the alignment count.

Top module: `adc_clk_resync`

## Requirements
- R1: After reset, `adc_clk` and `sample_stb` stay low until the first rising edge of `pix_sync`.
- R2: After a clock edge that samples `pix_sync` high when it was low at the previous edge, the next rising edge of `adc_clk` occurs exactly ALIGN_CYC (default 16) clock edges later. This holds whatever phase the divider was in.
- R3: Between syncs the divider runs free, with half-high, half-low periods. Code 0 gives a period of 4 cycles, code 1 gives 8, and codes 2 and 3 give 16.
- R4: `rate_sel` is captured only at the edge that detects a sync. A change at any other time does not affect the period until the next sync.
- R5: `sample_stb` is high for exactly the first system cycle of each high phase of `adc_clk`, and at no other time.
- R6: No high phase of `adc_clk` is shortened or lengthened: it always lasts half the period of the ratio in force when it began. No low phase is shorter than half the shortest period.
- R7: `pix_sync` is edge-detected. Holding it high for many cycles produces one realignment only, and the divider then runs free while the input is still high.
- R8: A second sync that arrives during the stretched phase restarts the alignment, so the next rising edge is timed from the later sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_sync | input | 1 | Pixel start marker; its rising edge realigns the divider |
| rate_sel | input | SEL_W (2) | Division ratio code, captured at each sync |
| adc_clk | output | 1 | Square conversion clock, driven directly from a state bit |
| sample_stb | output | 1 | One-cycle pulse on each `adc_clk` rising edge |

## Verification
The syncs are placed at many different offsets after the last expected rising edge: at the strobe itself, inside the high half, and late in the low half. Matching every strobe to an exact predicted cycle then separates a stretch that honours the full alignment delay from one that cuts a phase short or skips the hold. Every code, including the clamped one, is run for several periods, and each high phase is timed, which confirms the ratio decode. Three further patterns each isolate one mechanism:
- a `rate_sel` change a few cycles after each sync, which shows that the ratio is latched only at the edge;
- a sync held high for forty cycles, which shows that the input is edge-detected rather than level-sensitive;
- a pair of closely spaced syncs, which shows that the alignment restarts.

// File: rtl/adc_clk_resync_pkg.sv
package adc_clk_resync_pkg;

    // Bit 0 of every encoding is the level of the ADC clock, so the clock
    // pin is one flop output with no decode in front of it.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'b000,
        ST_RUN_LO  = 3'b010,
        ST_HOLD_LO = 3'b100,
        ST_RUN_HI  = 3'b011,
        ST_HOLD_HI = 3'b101
    } divstate_e;

endpackage

// File: rtl/adc_clk_resync_edge.sv
module adc_clk_resync_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic rise_out
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_in;
        end
    end

    // High for one cycle on a low-to-high change, however long the level stays.
    assign rise_out = level_in & ~level_q;

endmodule

// File: rtl/adc_clk_resync_ratio.sv
module adc_clk_resync_ratio #(
    parameter int SEL_W     = 2,
    parameter int BASE_DIV  = 4,
    parameter int NUM_RATES = 3
) (
    input  logic [SEL_W-1:0]                                          code_in,
    output logic [$clog2(((BASE_DIV/2) << (NUM_RATES-1)) + 1)-1:0] half_out
);

    localparam int BASE_HALF = BASE_DIV / 2;
    localparam int MAX_HALF  = BASE_HALF << (NUM_RATES - 1);
    localparam int HALF_W    = $clog2(MAX_HALF + 1);

    // Codes beyond the last ratio fall back to the slowest one.
    always_comb begin
        half_out = HALF_W'(MAX_HALF);
        for (int i = 0; i < NUM_RATES; i++) begin
            if (int'(code_in) == i) begin
                half_out = HALF_W'(BASE_HALF << i);
            end
        end
    end

endmodule

// File: rtl/adc_clk_resync_fsm.sv
module adc_clk_resync_fsm
    import adc_clk_resync_pkg::*;
#(
    parameter int SEL_W     = 2,
    parameter int BASE_DIV  = 4,
    parameter int NUM_RATES = 3,
    parameter int ALIGN_CYC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_evt,
    input  logic [SEL_W-1:0] code_in,
    output logic             clk_level,
    output logic             rise_stb
);

    localparam int MAX_HALF = (BASE_DIV / 2) << (NUM_RATES - 1);
    localparam int HALF_W   = $clog2(MAX_HALF + 1);
    localparam int ALIGN_W  = $clog2(ALIGN_CYC);

    divstate_e          state_q, state_d;
    logic [HALF_W-1:0]  phase_q, phase_d;
    logic [ALIGN_W-1:0] align_q, align_d;
    logic [SEL_W-1:0]   act_code_q, act_code_d;
    logic [SEL_W-1:0]   pend_code_q, pend_code_d;
    logic [HALF_W-1:0]  act_half;
    logic               half_done;
    logic               align_done;

    adc_clk_resync_ratio #(
        .SEL_W    (SEL_W),
        .BASE_DIV (BASE_DIV),
        .NUM_RATES(NUM_RATES)
    ) u_ratio (
        .code_in (act_code_q),
        .half_out(act_half)
    );

    assign half_done  = (phase_q == act_half - HALF_W'(1));
    assign align_done = (align_q == ALIGN_W'(ALIGN_CYC - 1));

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            phase_q     <= '0;
            align_q     <= '0;
            act_code_q  <= '0;
            pend_code_q <= '0;
        end else begin
            state_q     <= state_d;
            phase_q     <= phase_d;
            align_q     <= align_d;
            act_code_q  <= act_code_d;
            pend_code_q <= pend_code_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d     = state_q;
        phase_d     = phase_q;
        align_d     = align_q;
        act_code_d  = act_code_q;
        pend_code_d = pend_code_q;
        if (sync_evt) begin
            pend_code_d = code_in;
        end
        unique case (state_q)
            ST_IDLE: begin
                if (sync_evt) begin
                    state_d = ST_HOLD_LO;
                    align_d = '0;
                end
            end
            ST_RUN_HI: begin
                if (sync_evt) begin
                    align_d = '0;
                    if (half_done) begin
                        state_d = ST_HOLD_LO;
                    end else begin
                        state_d = ST_HOLD_HI;
                        phase_d = phase_q + HALF_W'(1);
                    end
                end else if (half_done) begin
                    state_d = ST_RUN_LO;
                    phase_d = '0;
                end else begin
                    phase_d = phase_q + HALF_W'(1);
                end
            end
            ST_RUN_LO: begin
                if (sync_evt) begin
                    state_d = ST_HOLD_LO;
                    align_d = '0;
                end else if (half_done) begin
                    state_d = ST_RUN_HI;
                    phase_d = '0;
                end else begin
                    phase_d = phase_q + HALF_W'(1);
                end
            end
            ST_HOLD_HI: begin
                align_d = sync_evt ? '0 : align_q + ALIGN_W'(1);
                if (half_done) begin
                    state_d = ST_HOLD_LO;
                end else begin
                    phase_d = phase_q + HALF_W'(1);
                end
            end
            ST_HOLD_LO: begin
                if (sync_evt) begin
                    align_d = '0;
                end else if (align_done) begin
                    state_d    = ST_RUN_HI;
                    phase_d    = '0;
                    act_code_d = pend_code_q;
                end else begin
                    align_d = align_q + ALIGN_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        clk_level = state_q[0];
        rise_stb  = (state_q == ST_RUN_HI) && (phase_q == '0);
    end

endmodule

// File: rtl/adc_clk_resync.sv
module adc_clk_resync #(
    parameter int SEL_W     = 2,
    parameter int BASE_DIV  = 4,
    parameter int NUM_RATES = 3,
    parameter int ALIGN_CYC = BASE_DIV << (NUM_RATES - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_sync,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             adc_clk,
    output logic             sample_stb
);

    logic sync_rise;

    adc_clk_resync_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_in(pix_sync),
        .rise_out(sync_rise)
    );

    adc_clk_resync_fsm #(
        .SEL_W    (SEL_W),
        .BASE_DIV (BASE_DIV),
        .NUM_RATES(NUM_RATES),
        .ALIGN_CYC(ALIGN_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .sync_evt (sync_rise),
        .code_in  (rate_sel),
        .clk_level(adc_clk),
        .rise_stb (sample_stb)
    );

endmodule

// File: rtl/adc_clk_resync_chk.sv
module adc_clk_resync_chk #(
    parameter int MIN_HALF  = 2,
    parameter int ALIGN_CYC = 16
) (
    input logic clk,
    input logic rst,
    input logic pix_sync,
    input logic adc_clk,
    input logic sample_stb
);

    logic       sync_prev;
    logic       adc_prev;
    logic       seen_sync;
    logic       first_pending;
    logic [7:0] hi_run;
    logic [7:0] lo_run;
    logic [7:0] since_sync;
    logic       evt;

    assign evt = pix_sync && !sync_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_prev     <= 1'b0;
            adc_prev      <= 1'b0;
            seen_sync     <= 1'b0;
            first_pending <= 1'b0;
            hi_run        <= '0;
            lo_run        <= '0;
            since_sync    <= '0;
        end else begin
            sync_prev <= pix_sync;
            adc_prev  <= adc_clk;
            hi_run    <= adc_clk ? ((hi_run == 8'hff) ? hi_run : hi_run + 8'd1) : 8'd0;
            lo_run    <= !adc_clk ? ((lo_run == 8'hff) ? lo_run : lo_run + 8'd1) : 8'd0;
            if (evt) begin
                seen_sync     <= 1'b1;
                first_pending <= 1'b1;
                since_sync    <= 8'd1;
            end else begin
                if (adc_clk && !adc_prev) first_pending <= 1'b0;
                if (since_sync != 8'hff) since_sync <= since_sync + 8'd1;
            end
        end
    end

    AST_QUIET_BEFORE_SYNC: assert property (@(posedge clk) disable iff (rst)
        !seen_sync |-> !adc_clk); // R1

    AST_FIRST_RISE_OFFSET: assert property (@(posedge clk) disable iff (rst)
        ($rose(adc_clk) && first_pending) |-> (int'(since_sync) == ALIGN_CYC + 1)); // R2

    AST_STROBE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (adc_clk && !$past(adc_clk))); // R5

    AST_RISE_HAS_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_clk) |-> sample_stb); // R5

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb); // R5

    AST_HIGH_NOT_CUT: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_clk) |-> (int'(hi_run) >= MIN_HALF)); // R6

    AST_LOW_NOT_CUT: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_clk) |-> (int'(lo_run) >= MIN_HALF)); // R6

endmodule

bind adc_clk_resync adc_clk_resync_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_sync  (pix_sync),
    .adc_clk   (adc_clk),
    .sample_stb(sample_stb)
);

// File: tb/adc_clk_resync_test.sv
module adc_clk_resync_test;

    localparam int CLK_PERIOD = 10;
    localparam int ALIGN      = 16;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        int    t;
        int    half;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_sync = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       adc_clk;
    logic       sample_stb;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;
    bit   adc_was = 1'b0;
    int   hi_len = 0;
    int   cur_half = 0;
    exp_t q[$];
    exp_t e;

    adc_clk_resync uut (
        .clk       (clk),
        .rst       (rst),
        .pix_sync  (pix_sync),
        .rate_sel  (rate_sel),
        .adc_clk   (adc_clk),
        .sample_stb(sample_stb)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int div_of(input int code);
        return 4 << ((code > 2) ? 2 : code);
    endfunction

    // Monitor: pop expected strobes and compare as the design produces them.
    always @(negedge clk) begin
        if (mon_on) begin
            if ((adc_clk && !adc_was) || sample_stb) begin
                checks++;
                if (sample_stb != (adc_clk && !adc_was)) begin
                    errors++;
                    $display("FAIL R5: strobe=%0d rise=%0d at cycle %0d, expected equal",
                             sample_stb, adc_clk && !adc_was, cyc);
                end
            end
            while (q.size() > 0 && q[0].t < cyc) begin
                checks++;
                errors++;
                $display("FAIL %s: no strobe at cycle %0d, got none, expected one", q[0].tag, q[0].t);
                void'(q.pop_front());
            end
            if (sample_stb) begin
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R3: strobe at cycle %0d, expected none", cyc);
                end else if (q[0].t != cyc) begin
                    errors++;
                    $display("FAIL %s: strobe at cycle %0d, expected cycle %0d", q[0].tag, cyc, q[0].t);
                end else begin
                    e = q.pop_front();
                    cur_half = e.half;
                end
            end
            if (adc_clk) begin
                hi_len++;
            end else if (hi_len > 0) begin
                checks++;
                if (hi_len != cur_half) begin
                    errors++;
                    $display("FAIL R6: high phase %0d cycles, expected %0d", hi_len, cur_half);
                end
                hi_len = 0;
            end
        end
        adc_was = adc_clk;
    end

    // Driver: one pixel with sync held for 'hold' cycles and a ratio
    // change 'noise' applied 3 cycles after the sync.
    task automatic run_pixel(input int code, input int noise, input int periods,
                             input int gap, input int hold, input string first_tag);
        int d = div_of(code);
        int start = cyc;
        int t0 = start + ALIGN + 1;
        int stop = t0 + (periods - 1) * d + gap;
        rate_sel = 2'(code);
        pix_sync = 1'b1;
        for (int i = 0; i < periods; i++) begin
            q.push_back('{t0 + i * d, d / 2,
                          (i == 0) ? first_tag : ((noise != code) ? "R4" : "R3")});
        end
        while (cyc < stop) begin
            @(negedge clk);
            if (cyc - start >= hold) pix_sync = 1'b0;
            if (cyc - start == 3) rate_sel = 2'(noise);
        end
    endtask

    // Two syncs 5 cycles apart: alignment counts from the second one.
    task automatic double_pixel(input int code, input int periods, input int gap);
        int d = div_of(code);
        int start = cyc;
        int t0 = start + 5 + ALIGN + 1;
        int stop = t0 + (periods - 1) * d + gap;
        rate_sel = 2'(code);
        pix_sync = 1'b1;
        for (int i = 0; i < periods; i++) begin
            q.push_back('{t0 + i * d, d / 2, (i == 0) ? "R8" : "R3"});
        end
        while (cyc < stop) begin
            @(negedge clk);
            pix_sync = (cyc - start == 5);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        rate_sel = 2'd2;
        mon_on = 1'b1;
        // R1: quiet until the first sync
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            checks++;
            if (adc_clk || sample_stb) begin
                errors++;
                $display("FAIL R1: adc_clk=%0d strobe=%0d, expected 0 0", adc_clk, sample_stb);
            end
        end
        run_pixel(0, 2, 6, 1, 1, "R2");
        run_pixel(1, 0, 5, 3, 2, "R2");
        run_pixel(2, 1, 4, 2, 40, "R7");
        run_pixel(3, 0, 3, 12, 1, "R2");
        run_pixel(0, 3, 4, 0, 1, "R2");
        double_pixel(1, 3, 5);
        run_pixel(2, 0, 2, 9, 1, "R2");
        run_pixel(1, 2, 3, 6, 1, "R2");
        run_pixel(0, 1, 2, 0, 1, "R2");
        @(negedge clk);
        mon_on = 1'b0;
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R3: %0d strobes outstanding, expected 0", q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run still going at cycle %0d, expected done", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule